// File: doc/BRIEF.md
# Unstructured TDM Pseudowire Packetizer

This block turns the octet stream of one unstructured TDM line (E1, T1, E3 or T3) into fixed-size pseudowire payload packets. Each packet starts with a 4-byte control word, optionally followed by a 12-byte RTP header, and then carries a run of line octets. The octets are passed through in arrival order, with no search for framing inside them. The payload length depends on the line type. A per-packet 16-bit sequence number and a 32-bit timestamp are kept inside the block.

The packet leaves on a byte stream with valid/ready handshaking and start/end markers. Payload octets cut straight through from the line input to the output, so the line input is held off while header bytes are sent and whenever the downstream stalls. A fault input marks the packet payload invalid and replaces its content with 0xFF. A loss input raises the remote-loss flag. Both flags, the line type and the RTP enable are sampled when the first byte of a packet is accepted, and they stay fixed for the rest of that packet.

Top module: `tdm_pw_packetizer`

## Requirements
- R1: With the fault flag clear, payload bytes equal the line octets in the order they were accepted on the line input, unchanged.
- R2: Payload length is 256 bytes for line type 0 (E1), 192 bytes for line type 1 (T1) and 1024 bytes for line types 2 and 3 (E3, T3). The line type is sampled when the first packet byte is accepted.
- R3: Control word bytes, most significant first: byte 0 = {4'b0000, L, R, 2'b00}, byte 1 = 0x00 (fragment bits and length field both zero), bytes 2-3 = sequence number, big-endian.
- R4: L equals fault_i at the acceptance of the first packet byte. When L is set, every payload byte is 0xFF and line octets are still consumed one per payload byte.
- R5: R equals loss_i at the acceptance of the first packet byte. Changes of fault_i or loss_i later in the packet have no effect on that packet.
- R6: The sequence number is 0 for the first packet after reset, rises by one per packet, and wraps from 0xFFFF to 0.
- R7: With rtp_en_i high at the first byte, bytes 4-15 are the RTP header: 0x80, {1'b0, rtp_pt_i}, the sequence number (2 bytes), the timestamp (4 bytes) and rtp_ssrc_i (4 bytes), all big-endian. With it low, payload follows byte 3.
- R8: The timestamp is 0 for the first packet and grows by that packet's payload length after each packet, modulo 2^32.
- R9: pkt_sop_o marks the first control-word byte and pkt_eop_o marks the last payload byte. The two never mark the same byte.
- R10: During header bytes pkt_valid_o is 1 and tdm_ready_o is 0. A stalled header byte holds its value. During payload, pkt_valid_o follows tdm_valid_i and tdm_ready_o follows pkt_ready_i.
- R11: After reset the block presents the first control-word byte: pkt_sop_o=1, pkt_valid_o=1, tdm_ready_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdm_data_i | input | 8 | Line octet |
| tdm_valid_i | input | 1 | Line octet present |
| tdm_ready_o | output | 1 | Line octet accepted this cycle when valid |
| line_type_i | input | 2 | 0 E1, 1 T1, 2 E3, 3 T3 |
| rtp_en_i | input | 1 | Insert RTP header |
| rtp_pt_i | input | 7 | RTP payload type |
| rtp_ssrc_i | input | 32 | RTP source identifier |
| fault_i | input | 1 | Attachment-circuit fault, sets L |
| loss_i | input | 1 | Local packet-loss state, sets R |
| pkt_data_o | output | 8 | Packet byte |
| pkt_valid_o | output | 1 | Packet byte present |
| pkt_ready_i | input | 1 | Downstream accepts byte |
| pkt_sop_o | output | 1 | First byte of packet |
| pkt_eop_o | output | 1 | Last byte of packet |

## Verification
Every output is combinational in the same cycle as its inputs: header bytes come from registered state, and payload bytes come straight from the line input. The bench therefore drives inputs just after a rising edge and compares all outputs with its model at the following falling edge. Flag, line-type and RTP-enable snapshots take effect from the cycle after the first byte is accepted. The sequence number and timestamp move one cycle after the last payload byte is accepted, and the model advances its own copies at those same handshakes. Packet length, sequence, timestamp and byte 0 are also collected per packet and compared at the end against values derived only from the stimulus list.

// File: rtl/tdm_pw_pkg.sv
package tdm_pw_pkg;
  typedef enum logic [1:0] {
    LINE_E1 = 2'd0,
    LINE_T1 = 2'd1,
    LINE_E3 = 2'd2,
    LINE_T3 = 2'd3
  } line_e;

  localparam int CW_BYTES  = 4;
  localparam int RTP_BYTES = 12;
  localparam int HDR_MAX   = CW_BYTES + RTP_BYTES;
  localparam int HDR_IDX_W = $clog2(HDR_MAX);
  localparam int SEQ_W     = 16;
  localparam int TS_W      = 32;
endpackage

// File: rtl/pw_len_sel.sv
module pw_len_sel
  import tdm_pw_pkg::*;
#(
  parameter int E1_LEN = 256,
  parameter int T1_LEN = 192,
  parameter int T3_LEN = 1024,
  parameter int PAY_W  = 11
) (
  input  line_e             line_i,
  output logic [PAY_W-1:0]  len_o
);
  always_comb begin
    unique case (line_i)
      LINE_E1: len_o = PAY_W'(E1_LEN);
      LINE_T1: len_o = PAY_W'(T1_LEN);
      default: len_o = PAY_W'(T3_LEN);
    endcase
  end
endmodule

// File: rtl/pw_seq_state.sv
module pw_seq_state
  import tdm_pw_pkg::*;
#(
  parameter int PAY_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [PAY_W-1:0]  len_i,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [TS_W-1:0]   ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_o <= '0;
      ts_o  <= '0;
    end else if (adv_i) begin
      seq_o <= seq_o + SEQ_W'(1);
      ts_o  <= ts_o + TS_W'(len_i);
    end
  end

  assert_seq_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> seq_o == $past(seq_o) + SEQ_W'(1));
  assert_seq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(seq_o));
  assert_ts_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ts_o == $past(ts_o) + TS_W'($past(len_i)));
endmodule

// File: rtl/pw_hdr_mux.sv
module pw_hdr_mux
  import tdm_pw_pkg::*;
(
  input  logic [HDR_IDX_W-1:0] idx_i,
  input  logic                 l_flag_i,
  input  logic                 r_flag_i,
  input  logic [SEQ_W-1:0]     seq_i,
  input  logic [TS_W-1:0]      ts_i,
  input  logic [6:0]           pt_i,
  input  logic [31:0]          ssrc_i,
  output logic [7:0]           byte_o
);
  logic [8*HDR_MAX-1:0] hdr_vec;

  // control word, then fixed RTP header (V=2, P=X=CC=M=0)
  assign hdr_vec = {4'b0000, l_flag_i, r_flag_i, 2'b00, 8'h00, seq_i,
                    8'h80, 1'b0, pt_i, seq_i, ts_i, ssrc_i};

  assign byte_o = hdr_vec[8*HDR_MAX-1 - 8*idx_i -: 8];
endmodule

// File: rtl/tdm_pw_packetizer.sv
module tdm_pw_packetizer
  import tdm_pw_pkg::*;
#(
  parameter int E1_LEN = 256,
  parameter int T1_LEN = 192,
  parameter int T3_LEN = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  tdm_data_i,
  input  logic        tdm_valid_i,
  output logic        tdm_ready_o,
  input  logic [1:0]  line_type_i,
  input  logic        rtp_en_i,
  input  logic [6:0]  rtp_pt_i,
  input  logic [31:0] rtp_ssrc_i,
  input  logic        fault_i,
  input  logic        loss_i,
  output logic [7:0]  pkt_data_o,
  output logic        pkt_valid_o,
  input  logic        pkt_ready_i,
  output logic        pkt_sop_o,
  output logic        pkt_eop_o
);
  localparam int MAX_LEN = (E1_LEN > T1_LEN) ? ((E1_LEN > T3_LEN) ? E1_LEN : T3_LEN)
                                             : ((T1_LEN > T3_LEN) ? T1_LEN : T3_LEN);
  localparam int PAY_W   = $clog2(MAX_LEN + 1);

  logic                 in_pay;
  logic [HDR_IDX_W-1:0] hdr_idx;
  logic [PAY_W-1:0]     pay_cnt;
  logic                 fault_q, loss_q, rtp_q;
  line_e                line_q;

  logic                 at_first;
  logic                 cur_fault, cur_loss, cur_rtp;
  line_e                cur_line;
  logic [HDR_IDX_W-1:0] hdr_last;
  logic [PAY_W-1:0]     pay_len;
  logic                 pay_last, pkt_done;
  logic [SEQ_W-1:0]     seq;
  logic [TS_W-1:0]      ts;
  logic [7:0]           hdr_byte;

  // live inputs govern the first byte; snapshot governs the rest
  assign at_first  = !in_pay && (hdr_idx == '0);
  assign cur_fault = at_first ? fault_i : fault_q;
  assign cur_loss  = at_first ? loss_i  : loss_q;
  assign cur_rtp   = at_first ? rtp_en_i : rtp_q;
  assign cur_line  = at_first ? line_e'(line_type_i) : line_q;
  assign hdr_last  = cur_rtp ? HDR_IDX_W'(HDR_MAX - 1) : HDR_IDX_W'(CW_BYTES - 1);

  pw_len_sel #(
    .E1_LEN (E1_LEN),
    .T1_LEN (T1_LEN),
    .T3_LEN (T3_LEN),
    .PAY_W  (PAY_W)
  ) u_len (
    .line_i (cur_line),
    .len_o  (pay_len)
  );

  pw_seq_state #(.PAY_W(PAY_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (pkt_done),
    .len_i  (pay_len),
    .seq_o  (seq),
    .ts_o   (ts)
  );

  pw_hdr_mux u_hdr (
    .idx_i    (hdr_idx),
    .l_flag_i (cur_fault),
    .r_flag_i (cur_loss),
    .seq_i    (seq),
    .ts_i     (ts),
    .pt_i     (rtp_pt_i),
    .ssrc_i   (rtp_ssrc_i),
    .byte_o   (hdr_byte)
  );

  assign pay_last    = (pay_cnt == pay_len - PAY_W'(1));
  assign pkt_valid_o = in_pay ? tdm_valid_i : 1'b1;
  assign tdm_ready_o = in_pay && pkt_ready_i;
  assign pkt_data_o  = in_pay ? (fault_q ? 8'hFF : tdm_data_i) : hdr_byte;
  assign pkt_sop_o   = at_first;
  assign pkt_eop_o   = in_pay && tdm_valid_i && pay_last;
  assign pkt_done    = pkt_eop_o && pkt_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pay  <= 1'b0;
      hdr_idx <= '0;
      pay_cnt <= '0;
      fault_q <= 1'b0;
      loss_q  <= 1'b0;
      rtp_q   <= 1'b0;
      line_q  <= LINE_E1;
    end else begin
      if (at_first) begin
        fault_q <= fault_i;
        loss_q  <= loss_i;
        rtp_q   <= rtp_en_i;
        line_q  <= line_e'(line_type_i);
      end
      if (!in_pay && pkt_ready_i) begin
        if (hdr_idx == hdr_last) begin
          hdr_idx <= '0;
          in_pay  <= 1'b1;
        end else begin
          hdr_idx <= hdr_idx + HDR_IDX_W'(1);
        end
      end
      if (in_pay && tdm_valid_i && pkt_ready_i) begin
        if (pay_last) begin
          pay_cnt <= '0;
          in_pay  <= 1'b0;
        end else begin
          pay_cnt <= pay_cnt + PAY_W'(1);
        end
      end
    end
  end

  assert_len_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pay |-> pay_cnt < pay_len);
  assert_hdr_no_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_sop_o |-> !tdm_ready_o);
  assert_sop_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_sop_o && !pkt_ready_i) |=> pkt_sop_o);
  assert_hdr_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_pay && hdr_idx != '0 && !pkt_ready_i) |=> $stable(pkt_data_o));
  assert_marker_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_sop_o && pkt_eop_o));
  assert_done_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done |=> pkt_sop_o);
endmodule

// File: tb/tdm_pw_packetizer_test.sv
module tdm_pw_packetizer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tdm_data = 8'h00;
  logic        tdm_valid = 1'b0;
  logic        tdm_ready;
  logic [1:0]  line_type = 2'd0;
  logic        rtp_en = 1'b0;
  logic [6:0]  rtp_pt = 7'h5A;
  logic [31:0] rtp_ssrc = 32'hC0FF_EE11;
  logic        fault = 1'b0;
  logic        loss = 1'b0;
  logic [7:0]  pkt_data;
  logic        pkt_valid;
  logic        pkt_ready = 1'b0;
  logic        pkt_sop;
  logic        pkt_eop;

  tdm_pw_packetizer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tdm_data_i(tdm_data), .tdm_valid_i(tdm_valid), .tdm_ready_o(tdm_ready),
    .line_type_i(line_type), .rtp_en_i(rtp_en), .rtp_pt_i(rtp_pt), .rtp_ssrc_i(rtp_ssrc),
    .fault_i(fault), .loss_i(loss),
    .pkt_data_o(pkt_data), .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready),
    .pkt_sop_o(pkt_sop), .pkt_eop_o(pkt_eop)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int len_of(int lt);
    if (lt == 0) return 256;
    if (lt == 1) return 192;
    return 1024;
  endfunction

  // stimulus modes
  int vmode = 0;
  int rmode = 0;
  always @(posedge clk) begin
    #1;
    tdm_data  = 8'($urandom);
    tdm_valid = (vmode == 0) ? 1'b1 : (($urandom % 4) != 0);
    pkt_ready = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  // behavioural model state
  int          pos = 0;
  bit          m_l, m_r;
  int          m_hdr, m_plen;
  int          m_seq = 0;
  int unsigned m_ts = 0;

  // independent per-packet capture
  int          cap_len, cap_b0, cap_seq;
  longint      cap_ts;
  int          got_len[$], got_b0[$], got_seq[$];
  longint      got_ts[$];
  int          eop_cnt = 0;

  function automatic logic [7:0] hdr_byte(int i, bit l, bit r, int seq, int unsigned ts);
    case (i)
      0:  return {4'b0000, l, r, 2'b00};
      1:  return 8'h00;
      2:  return 8'(seq >> 8);
      3:  return 8'(seq);
      4:  return 8'h80;
      5:  return {1'b0, rtp_pt};
      6:  return 8'(seq >> 8);
      7:  return 8'(seq);
      8:  return ts[31:24];
      9:  return ts[23:16];
      10: return ts[15:8];
      11: return ts[7:0];
      12: return rtp_ssrc[31:24];
      13: return rtp_ssrc[23:16];
      14: return rtp_ssrc[15:8];
      default: return rtp_ssrc[7:0];
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit l, r, ev, er, es, ee, fire;
      int hl, pl;
      logic [7:0] ed;
      string tag;
      l  = (pos == 0) ? fault : m_l;
      r  = (pos == 0) ? loss  : m_r;
      hl = (pos == 0) ? (rtp_en ? 16 : 4) : m_hdr;
      pl = (pos == 0) ? len_of(int'(line_type)) : m_plen;
      if (pos < hl) begin
        ev = 1'b1; er = 1'b0; es = (pos == 0); ee = 1'b0;
        ed = hdr_byte(pos, l, r, m_seq, m_ts);
        tag = (pos < 4) ? "R3" : "R7";
      end else begin
        ev = tdm_valid; er = pkt_ready; es = 1'b0;
        ee = tdm_valid && (pos == hl + pl - 1);
        ed = l ? 8'hFF : tdm_data;
        tag = l ? "R4" : "R1";
      end
      chk(pkt_valid == ev, "R10", "valid", pkt_valid, ev);
      chk(tdm_ready == er, "R10", "line ready", tdm_ready, er);
      chk(pkt_sop == es, "R9", "sop", pkt_sop, es);
      chk(pkt_eop == ee, "R9", "eop", pkt_eop, ee);
      if (ev) chk(pkt_data == ed, tag, $sformatf("byte %0d", pos), pkt_data, ed);

      // capture at the port, independent of the model
      if (pkt_valid && pkt_ready) begin
        if (pkt_sop) begin cap_len = 0; cap_ts = -1; cap_seq = 0; cap_b0 = pkt_data; end
        if (cap_len == 2 || cap_len == 3) cap_seq = (cap_seq << 8) | pkt_data;
        if (rtp_en_at_first && cap_len >= 8 && cap_len <= 11)
          cap_ts = ((cap_len == 8) ? 0 : (cap_ts << 8)) | pkt_data;
        cap_len++;
        if (pkt_eop) begin
          got_len.push_back(cap_len); got_b0.push_back(cap_b0);
          got_seq.push_back(cap_seq); got_ts.push_back(cap_ts);
          eop_cnt++;
        end
      end

      fire = ev && pkt_ready;
      if (fire) begin
        if (pos == 0) begin m_l = l; m_r = r; m_hdr = hl; m_plen = pl; end
        pos++;
        if (pos == m_hdr + m_plen) begin
          pos = 0;
          m_seq = (m_seq + 1) & 16'hFFFF;
          m_ts = m_ts + m_plen;
        end
      end
    end
  end

  // RTP enable seen by the current packet, tracked from the stimulus
  bit rtp_en_at_first = 1'b0;
  always @(negedge clk) if (rst_n && pkt_sop && pkt_valid && pkt_ready) rtp_en_at_first = rtp_en;

  int cfg_lt[8]  = '{0, 1, 2, 3, 0, 1, 0, 1};
  bit cfg_rtp[8] = '{0, 1, 1, 0, 1, 1, 0, 1};
  bit cfg_f[8]   = '{0, 0, 1, 1, 0, 1, 0, 0};
  bit cfg_l[8]   = '{0, 1, 0, 1, 0, 0, 1, 0};
  int cfg_vm[8]  = '{0, 1, 0, 1, 1, 0, 1, 0};
  int cfg_rm[8]  = '{0, 0, 1, 1, 1, 0, 1, 1};

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1200000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    fault = 1'b0; loss = 1'b1; line_type = 2'd0; rtp_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11: outputs while held in reset
    chk(pkt_sop == 1'b1 && pkt_valid == 1'b1, "R11", "sop/valid in reset", {pkt_sop, pkt_valid}, 2'b11);
    chk(tdm_ready == 1'b0, "R11", "line ready in reset", tdm_ready, 0);
    chk(pkt_data == 8'h04, "R11", "first byte in reset", pkt_data, 8'h04);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      int target;
      target    = eop_cnt + 1;
      line_type = 2'(cfg_lt[k]);
      rtp_en    = cfg_rtp[k];
      fault     = cfg_f[k];
      loss      = cfg_l[k];
      vmode     = cfg_vm[k];
      rmode     = cfg_rm[k];
      rtp_pt    = 7'(7'h20 + k);
      wait (pos != 0);
      @(posedge clk); #2;
      // R5: flags flipped mid-packet must be ignored
      fault = ~cfg_f[k];
      loss  = ~cfg_l[k];
      rtp_en = ~cfg_rtp[k];
      line_type = 2'(cfg_lt[k] + 1);
      wait (eop_cnt == target);
      @(posedge clk); #2;
    end

    begin
      int unsigned ts_exp;
      ts_exp = 0;
      chk(got_len.size() == 8, "R9", "packet count", got_len.size(), 8);
      for (int k = 0; k < 8 && k < got_len.size(); k++) begin
        int hl;
        hl = cfg_rtp[k] ? 16 : 4;
        chk(got_len[k] == hl + len_of(cfg_lt[k]), "R2", $sformatf("pkt %0d length", k),
            got_len[k], hl + len_of(cfg_lt[k]));
        chk(got_seq[k] == k, "R6", $sformatf("pkt %0d seq", k), got_seq[k], k);
        chk(got_b0[k] == {cfg_f[k], cfg_l[k], 2'b00}, "R5",
            $sformatf("pkt %0d flags byte", k), got_b0[k], {cfg_f[k], cfg_l[k], 2'b00});
        if (cfg_rtp[k])
          chk(got_ts[k] == longint'(ts_exp), "R8", $sformatf("pkt %0d timestamp", k),
              got_ts[k], ts_exp);
        ts_exp += len_of(cfg_lt[k]);
      end
    end
    finish_run();
  end
endmodule